// File: doc/BRIEF.md
# Test Access Port Controller with Identification and Boundary Registers

This block is the serial test and identification port of a small programmable-logic device. It is driven by a test clock `tck`, a mode select `tms` and serial data `tdi`. It walks the standard sixteen-state controller and decodes a 10-bit instruction. From that instruction it selects one data path between `tdi` and `tdo`: a 1-bit bypass stage, a fixed 32-bit identification word, a 32-bit user word, or a boundary register of `BSR_LEN` cells that samples and drives the device pins.

The controller states are Reset, Idle, and two columns of the same shape, one for data and one for instruction: Select, Capture, Shift, Exit1, Pause, Exit2 and Update. `tms` decides every transition.
- Reset stays in Reset while `tms`=1 and goes to Idle on 0.
- Idle stays in Idle on 0 and goes to Select-DR on 1.
- Select-DR goes to Capture-DR on 0 and to Select-IR on 1. Select-IR goes to Capture-IR on 0 and to Reset on 1.
- In each column:
  - Capture goes to Exit1 on 1 and to Shift on 0.
  - Shift stays in Shift on 0 and goes to Exit1 on 1.
  - Exit1 goes to Update on 1 and to Pause on 0.
  - Pause stays in Pause on 0 and goes to Exit2 on 1.
  - Exit2 goes to Update on 1 and back to Shift on 0.
- Update goes to Select-DR on 1 and to Idle on 0.

Capture loads the selected register in parallel. Shift moves it one bit toward `tdo` on each rising edge, LSB first. Update transfers the shifted value to its output latch.

The port also gates the device's user I/O. `io_inhibit` holds every user pin off until the programming-done status bit reports that programming has completed.

Top module: `tap_ident_ctrl`

## Requirements
- R1: On entry to Reset the current instruction becomes IDCODE. A data scan then returns the 32-bit word {VERSION[3:0], PART[15:0], MFR[10:0], 1'b1}, bit 0 first.
- R2: Five consecutive rising edges of `tck` with `tms`=1 bring the controller to Reset from any state.
- R3: The instruction register is 10 bits wide. Capture-IR loads 10'b0000000001, so bits [1:0] are 01 and the scan-out begins 1, 0.
- R4: The opcodes are EXTEST=10'h000, SAMPLE=10'h005, IDCODE=10'h006, USERCODE=10'h007 and BYPASS=10'h3FF. A new opcode takes effect at Update-IR.
- R5: Under USERCODE a data scan returns the 32-bit USERCODE parameter, bit 0 first.
- R6: Under BYPASS the data path is one stage that captures 0. An n-bit scan returns 0 followed by the first n-1 input bits.
- R7: Every opcode not listed in R4 selects the bypass stage.
- R8: Under SAMPLE or EXTEST the data path is the BSR_LEN-cell boundary register. Capture-DR loads `pin_in`, cell 0 is shifted out first, and Update-DR copies the shifted value to `pin_out`.
- R9: `test_drive` is 1 only while the current instruction is EXTEST.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: `io_inhibit` is 1 whenever `prog_done` is 0, and 0 when `prog_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset (used when HAS_TRST=1) |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| prog_done | input | 1 | Programming-complete status bit |
| io_inhibit | output | 1 | Holds all user I/O undriven |
| pin_in | input | BSR_LEN | Pin values captured by the boundary register |
| pin_out | output | BSR_LEN | Boundary update latch, drives pins in test mode |
| test_drive | output | 1 | Pins take their values from pin_out |

## Verification
The checks assume that `trst_n` is asserted at start-up, or that five `tms`=1 clocks reach Reset, before any other use. They also assume that `tms` and `tdi` are stable around each rising `tck` edge, and that `pin_in` and `prog_done` change only away from the edges that sample them. The stimulus changes `tms` and `tdi` one nanosecond after a falling edge and samples `tdo` at the same point. The stimulus pulses `trst_n` once at the start, and changes `pin_in` and `prog_done` only while the controller is idle.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 10;

    typedef enum logic [3:0] {
        S_RESET,
        S_IDLE,
        S_SEL_DR,
        S_CAP_DR,
        S_SH_DR,
        S_EX1_DR,
        S_PAUSE_DR,
        S_EX2_DR,
        S_UPD_DR,
        S_SEL_IR,
        S_CAP_IR,
        S_SH_IR,
        S_EX1_IR,
        S_PAUSE_IR,
        S_EX2_IR,
        S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYP,
        SEL_ID,
        SEL_USER,
        SEL_BSR
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST   = 10'h000;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
    localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
    localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
    localparam logic [IR_W-1:0] OP_BYPASS   = {IR_W{1'b1}};

    localparam logic [IR_W-1:0] IR_CAPTURE  = {{(IR_W-2){1'b0}}, 2'b01};

endpackage

// File: rtl/tap_state_fsm.sv
module tap_state_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state <= S_RESET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RESET:    nxt = tms ? S_RESET   : S_IDLE;
            S_IDLE:     nxt = tms ? S_SEL_DR  : S_IDLE;
            S_SEL_DR:   nxt = tms ? S_SEL_IR  : S_CAP_DR;
            S_CAP_DR:   nxt = tms ? S_EX1_DR  : S_SH_DR;
            S_SH_DR:    nxt = tms ? S_EX1_DR  : S_SH_DR;
            S_EX1_DR:   nxt = tms ? S_UPD_DR  : S_PAUSE_DR;
            S_PAUSE_DR: nxt = tms ? S_EX2_DR  : S_PAUSE_DR;
            S_EX2_DR:   nxt = tms ? S_UPD_DR  : S_SH_DR;
            S_UPD_DR:   nxt = tms ? S_SEL_DR  : S_IDLE;
            S_SEL_IR:   nxt = tms ? S_RESET   : S_CAP_IR;
            S_CAP_IR:   nxt = tms ? S_EX1_IR  : S_SH_IR;
            S_SH_IR:    nxt = tms ? S_EX1_IR  : S_SH_IR;
            S_EX1_IR:   nxt = tms ? S_UPD_IR  : S_PAUSE_IR;
            S_PAUSE_IR: nxt = tms ? S_EX2_IR  : S_PAUSE_IR;
            S_EX2_IR:   nxt = tms ? S_UPD_IR  : S_SH_IR;
            S_UPD_IR:   nxt = tms ? S_SEL_DR  : S_IDLE;
            default:    nxt = S_RESET;
        endcase
    end

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_cur
);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_shift <= '0;
            ir_cur   <= OP_IDCODE;
        end else begin
            unique case (state)
                S_RESET:  ir_cur   <= OP_IDCODE;
                S_CAP_IR: ir_shift <= IR_CAPTURE;
                S_SH_IR:  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
                S_UPD_IR: ir_cur   <= ir_shift;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
    import tap_pkg::*;
#(
    parameter int          BSR_LEN   = 192,
    parameter logic [31:0] ID_WORD   = 32'h1,
    parameter logic [31:0] USER_WORD = 32'h0
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_so,
    output logic [BSR_LEN-1:0] pin_out
);

    logic               byp_q;
    logic [31:0]        word_sr;
    logic [BSR_LEN-1:0] bsr_sr;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            byp_q   <= 1'b0;
            word_sr <= '0;
            bsr_sr  <= '0;
            pin_out <= '0;
        end else begin
            unique case (state)
                S_CAP_DR: begin
                    unique case (sel)
                        SEL_BYP:  byp_q   <= 1'b0;
                        SEL_ID:   word_sr <= ID_WORD;
                        SEL_USER: word_sr <= USER_WORD;
                        SEL_BSR:  bsr_sr  <= pin_in;
                    endcase
                end
                S_SH_DR: begin
                    unique case (sel)
                        SEL_BYP:  byp_q   <= tdi;
                        SEL_ID,
                        SEL_USER: word_sr <= {tdi, word_sr[31:1]};
                        SEL_BSR:  bsr_sr  <= {tdi, bsr_sr[BSR_LEN-1:1]};
                    endcase
                end
                S_UPD_DR: begin
                    if (sel == SEL_BSR) pin_out <= bsr_sr;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_BYP:  dr_so = byp_q;
            SEL_ID,
            SEL_USER: dr_so = word_sr[0];
            SEL_BSR:  dr_so = bsr_sr[0];
        endcase
    end

endmodule

// File: rtl/tap_ident_ctrl.sv
module tap_ident_ctrl
    import tap_pkg::*;
#(
    parameter int          BSR_LEN   = 192,
    parameter bit          HAS_TRST  = 1'b1,
    parameter logic [3:0]  VERSION   = 4'h3,
    parameter logic [15:0] PART      = 16'h4A64,
    parameter logic [10:0] MFR       = 11'h2B5,
    parameter logic [31:0] USERCODE  = 32'hC0DE_1234
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic               prog_done,
    output logic               io_inhibit,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic [BSR_LEN-1:0] pin_out,
    output logic               test_drive
);

    localparam logic [31:0] ID_WORD = {VERSION, PART, MFR, 1'b1};

    logic            rst_n;
    tap_state_e      state;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_cur;
    dr_sel_e         sel;
    logic            dr_so;
    logic            serial_out;
    logic            in_shift;

    generate
        if (HAS_TRST) begin : g_trst
            assign rst_n = trst_n;
        end else begin : g_no_trst
            assign rst_n = 1'b1;
        end
    endgenerate

    tap_state_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_instr_reg u_ir (
        .tck      (tck),
        .rst_n    (rst_n),
        .state    (state),
        .tdi      (tdi),
        .ir_shift (ir_shift),
        .ir_cur   (ir_cur)
    );

    always_comb begin
        case (ir_cur)
            OP_IDCODE:   sel = SEL_ID;
            OP_USERCODE: sel = SEL_USER;
            OP_SAMPLE,
            OP_EXTEST:   sel = SEL_BSR;
            default:     sel = SEL_BYP;
        endcase
    end

    tap_data_regs #(
        .BSR_LEN   (BSR_LEN),
        .ID_WORD   (ID_WORD),
        .USER_WORD (USERCODE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .state   (state),
        .sel     (sel),
        .tdi     (tdi),
        .pin_in  (pin_in),
        .dr_so   (dr_so),
        .pin_out (pin_out)
    );

    assign in_shift   = (state == S_SH_IR) || (state == S_SH_DR);
    assign serial_out = (state == S_SH_IR) ? ir_shift[0] : dr_so;

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= serial_out;
            tdo_oe <= in_shift;
        end
    end

    assign test_drive = (ir_cur == OP_EXTEST);
    assign io_inhibit = ~prog_done;

endmodule

// File: rtl/tap_ident_ctrl_chk.sv
module tap_ident_ctrl_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_shift,
    input logic [IR_W-1:0] ir_cur,
    input logic            tdo_oe
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 ones_run <= '0;
        else if (!tms)               ones_run <= '0;
        else if (ones_run != 3'd5)   ones_run <= ones_run + 3'd1;
    end

    // R2: five rising edges with tms high land in Reset
    a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == S_RESET));

    // R1: Reset makes IDCODE the current instruction
    a_r1_reset_loads_id: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_RESET) |=> (ir_cur == OP_IDCODE));

    // R3: Capture-IR puts 01 into the low instruction bits
    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_CAP_IR) |=> (ir_shift[1:0] == 2'b01));

    // R10: output enable follows the shift states
    a_r10_oe_shift_only: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((state == S_SH_IR) || (state == S_SH_DR)));

    // R4: the instruction changes only through Update-IR or Reset
    a_r4_ir_changes_at_update: assert property (@(posedge tck) disable iff (!trst_n)
        !((state == S_UPD_IR) || (state == S_RESET)) |=> $stable(ir_cur));

endmodule

bind tap_ident_ctrl tap_ident_ctrl_chk u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .state    (state),
    .ir_shift (ir_shift),
    .ir_cur   (ir_cur),
    .tdo_oe   (tdo_oe)
);

// File: tb/sim_tap_ident_ctrl.sv
module sim_tap_ident_ctrl;

    localparam int          N       = 192;
    localparam logic [31:0] EXP_ID  = {4'h3, 16'h4A64, 11'h2B5, 1'b1};
    localparam logic [31:0] EXP_UC  = 32'hC0DE_1234;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         prog_done = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         tdo, tdo_oe, io_inhibit, test_drive;
    logic [N-1:0] pin_out;

    int checks = 0;
    int fails  = 0;

    always #2 tck = ~tck;

    tap_ident_ctrl u0 (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .prog_done  (prog_done),
        .io_inhibit (io_inhibit),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .test_drive (test_drive)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // caller sits 1 ns after a falling edge; tdo is sampled before the rising edge
    task automatic clk(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        o   = tdo;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [255:0] din, output logic [255:0] dout);
        logic x;
        dout = '0;
        for (int i = 0; i < n; i++) begin
            logic o;
            clk(i == n - 1, din[i], o);
            dout[i] = o;
        end
        clk(1'b1, 1'b0, x);
        clk(1'b0, 1'b0, x);
    endtask

    task automatic scan_ir(input logic [9:0] op, output logic [9:0] cap);
        logic x;
        logic [255:0] d;
        clk(0, 0, x); clk(1, 0, x); clk(1, 0, x); clk(0, 0, x); clk(0, 0, x);
        shift_bits(10, {246'b0, op}, d);
        cap = d[9:0];
    endtask

    task automatic scan_dr(input int n, input logic [255:0] din, output logic [255:0] dout);
        logic x;
        clk(0, 0, x); clk(1, 0, x); clk(0, 0, x); clk(0, 0, x);
        shift_bits(n, din, dout);
    endtask

    task automatic t_reset;
        logic [255:0] d;
        trst_n = 1'b0;
        repeat (2) @(negedge tck);
        trst_n = 1'b1;
        #1;
        chk("R10 tdo_oe low after reset", tdo_oe, 1'b0);
        chk("R11 io_inhibit with prog_done low", io_inhibit, 1'b1);
        chk("R9 test_drive low after reset", test_drive, 1'b0);
        scan_dr(32, '0, d);
        chk("R1 identification word", d[31:0], EXP_ID);
    endtask

    task automatic t_ir_capture_user;
        logic [9:0]   cap;
        logic [255:0] d;
        scan_ir(10'h007, cap);
        chk("R3 capture-IR pattern", cap, 10'h001);
        scan_dr(32, '0, d);
        chk("R5 USERCODE word (R4 opcode 007)", d[31:0], EXP_UC);
    endtask

    task automatic t_bypass;
        logic [9:0]   cap;
        logic [255:0] d;
        scan_ir(10'h3FF, cap);
        scan_dr(8, 8'hB5, d);
        chk("R6 bypass one-stage delay", d[7:0], 8'h6A);
    endtask

    task automatic t_unknown;
        logic [9:0]   cap;
        logic [255:0] d;
        scan_ir(10'h123, cap);
        scan_dr(8, 8'h3C, d);
        chk("R7 unknown opcode acts as bypass", d[7:0], 8'h78);
        scan_ir(10'h2AA, cap);
        scan_dr(4, 4'hF, d);
        chk("R7 second unknown opcode", d[3:0], 4'hE);
    endtask

    task automatic t_sample;
        logic [9:0]   cap;
        logic [255:0] d;
        logic [N-1:0] din;
        pin_in = {6{32'hA5C3_0F96}};
        din    = {6{32'h1234_5678}} ^ {N{1'b1}};
        scan_ir(10'h005, cap);
        chk("R9 test_drive low under SAMPLE", test_drive, 1'b0);
        scan_dr(N, {64'b0, din}, d);
        chk("R8 boundary capture of pin_in", d[N-1:0], pin_in);
        chk("R8 boundary update to pin_out", pin_out, din);
    endtask

    task automatic t_extest;
        logic [9:0]   cap;
        logic [255:0] d;
        scan_ir(10'h000, cap);
        chk("R9 test_drive high under EXTEST", test_drive, 1'b1);
        scan_dr(N, {64'b0, {6{32'h0F0F_3355}}}, d);
        chk("R8 EXTEST update to pin_out", pin_out, {6{32'h0F0F_3355}});
    endtask

    task automatic t_tms_reset;
        logic [9:0]   cap;
        logic [255:0] d;
        logic         x;
        scan_ir(10'h007, cap);
        clk(0, 0, x); clk(1, 0, x); clk(0, 0, x); clk(0, 0, x);
        for (int i = 0; i < 5; i++) clk(1, 0, x);
        chk("R2 five tms ones clear test_drive", test_drive, 1'b0);
        scan_dr(32, '0, d);
        chk("R2 five tms ones restore IDCODE", d[31:0], EXP_ID);
    endtask

    task automatic t_oe_edge;
        logic x;
        clk(0, 0, x); clk(1, 0, x); clk(0, 0, x);
        chk("R10 tdo_oe low in Capture-DR", tdo_oe, 1'b0);
        tms = 1'b0;
        @(posedge tck);
        #1;
        chk("R10 tdo_oe waits for falling edge", tdo_oe, 1'b0);
        @(negedge tck);
        #1;
        chk("R10 tdo_oe high in Shift-DR", tdo_oe, 1'b1);
        clk(1, 0, x);
        chk("R10 tdo_oe low in Exit1-DR", tdo_oe, 1'b0);
        clk(1, 0, x);
        clk(0, 0, x);
    endtask

    task automatic t_inhibit;
        prog_done = 1'b1;
        #1;
        chk("R11 io_inhibit released when done", io_inhibit, 1'b0);
        prog_done = 1'b0;
        #1;
        chk("R11 io_inhibit set when not done", io_inhibit, 1'b1);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        @(negedge tck);
        #1;
        t_reset();
        t_ir_capture_user();
        t_bypass();
        t_unknown();
        t_sample();
        t_extest();
        t_tms_reset();
        t_oe_edge();
        t_inhibit();
        summary();
    end

    initial begin
        repeat (100000) @(posedge tck);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

endmodule